// File: doc/BRIEF.md
# Burst Address Counter with Selectable Beat Ordering

This block produces the address for four-beat burst accesses to a synchronous pipelined cache memory. When a processor-side or controller-side address strobe is seen low at a rising clock edge, the block takes in the full external address. That address is the first beat of a new burst. After that, an active-low advance input moves the two low address bits to the next beat on each edge where it is low. The upper bits stay fixed until the next strobe.

A static mode input picks the order in which the four beats are visited. Interleaved order XORs the start bits with the beat number. Linear order adds the beat number to the start bits and wraps modulo four. The block outputs the current full address, the beat number within the burst and which strobe opened the burst. The memory array and the data path sit outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is low and on the first edge after it, `addr_out` is 0, `beat_idx` is 0 and `burst_src` is 0.
- R2: A strobe (`proc_strobe_n` or `ctrl_strobe_n` low at a rising edge) loads `addr_in` whole: after that edge `addr_out` equals `addr_in` and `beat_idx` is 0.
- R3: `burst_src` reads 0 after a load by the processor strobe and 1 after a load by the controller strobe. When both strobes are low on the same edge, the processor strobe wins and `burst_src` reads 0.
- R4: With both strobes high and `advance_n` low at an edge, `beat_idx` increases by one modulo 4.
- R5: With `mode_linear` = 0 (interleaved), `addr_out[1:0]` equals the loaded start bits XOR `beat_idx`. For example, start 1 gives 1, 0, 3, 2.
- R6: With `mode_linear` = 1 (linear), `addr_out[1:0]` equals (start bits + `beat_idx`) mod 4. For example, start 1 gives 1, 2, 3, 0.
- R7: With both strobes high and `advance_n` high, all outputs hold their values.
- R8: `addr_out[ADDR_W-1:2]` stays at the loaded value through any number of advances and holds, until the next strobe.
- R9: A strobe in the middle of a burst restarts it at beat 0 from the new address, even if `advance_n` is low on the same edge.
- R10: After four advances the address returns to the start address of the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_linear | input | 1 | Beat order: 0 interleaved, 1 linear; static |
| proc_strobe_n | input | 1 | Processor-side address strobe, active low, has priority |
| ctrl_strobe_n | input | 1 | Controller-side address strobe, active low |
| advance_n | input | 1 | Step to the next beat, active low |
| addr_in | input | ADDR_W | External address, sampled on a strobe |
| addr_out | output | ADDR_W | Current burst address |
| beat_idx | output | 2 | Beat number within the burst |
| burst_src | output | 1 | Strobe that opened the burst: 0 processor, 1 controller |

## Verification
The hardest case to reach is a strobe that lands in the middle of a partly advanced burst. On that same edge the advance input is also low, so a restart competes with a step. The bench gets there by opening every burst under every combination of mode, start bits, upper-address pattern and strobe type. It then walks part of the sequence with holds mixed in, and fires a new strobe with advance held low. It also fires both strobes together, so the priority choice shows on `burst_src`.

// File: rtl/burst_pkg.sv
// Package: shared types and ordering helpers for the burst address counter.
// Assumes bursts of four beats addressed by two low address bits.
package burst_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        SRC_PROC = 1'b0,
        SRC_CTRL = 1'b1
    } burst_src_e;

    // Interleaved order: start bits XOR beat number.
    function automatic beat_t order_interleaved(input beat_t start, input beat_t beat);
        return start ^ beat;
    endfunction

    // Linear order: start bits plus beat number, wrapping modulo the beat count.
    function automatic beat_t order_linear(input beat_t start, input beat_t beat);
        return beat_t'(start + beat);
    endfunction

endpackage

// File: rtl/strobe_arbiter.sv
// Module: strobe_arbiter
// Decodes the two active-low strobes and the advance input into one action
// per edge: load (with its source), step, or hold. The processor strobe wins
// when both strobes are low. A load always outranks a step.
module strobe_arbiter
    import burst_pkg::*;
(
    input  logic       proc_strobe_n,
    input  logic       ctrl_strobe_n,
    input  logic       advance_n,
    output logic       do_load,
    output logic       do_step,
    output burst_src_e load_src
);

    // Action decode: a strobe forces a load, otherwise advance steps.
    always_comb begin
        do_load  = !proc_strobe_n || !ctrl_strobe_n;
        do_step  = !do_load && !advance_n;
        load_src = !proc_strobe_n ? SRC_PROC : SRC_CTRL;
    end

endmodule

// File: rtl/beat_counter.sv
// Module: beat_counter
// Holds the start bits of the current burst and a wrapping beat number.
// Assumes do_load and do_step are never high together (the arbiter ensures it).
module beat_counter
    import burst_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  do_load,
    input  logic  do_step,
    input  beat_t start_in,
    output beat_t start_q,
    output beat_t beat_q
);

    // Start register: captured on load only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_q <= '0;
        else if (do_load)
            start_q <= start_in;
    end

    // Beat number: cleared on load, incremented with wrap on step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            beat_q <= '0;
        else if (do_load)
            beat_q <= '0;
        else if (do_step)
            beat_q <= beat_q + beat_t'(1);
    end

endmodule

// File: rtl/upper_hold.sv
// Module: upper_hold
// Keeps the upper address bits and the burst source for the whole burst.
// Only a load may change them. UP_W must be at least 1.
module upper_hold
    import burst_pkg::*;
#(
    parameter int UP_W = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            do_load,
    input  logic [UP_W-1:0] upper_in,
    input  burst_src_e      src_in,
    output logic [UP_W-1:0] upper_q,
    output burst_src_e      src_q
);

    // Upper bits and source: loaded together on a strobe, else held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            src_q   <= SRC_PROC;
        end else if (do_load) begin
            upper_q <= upper_in;
            src_q   <= src_in;
        end
    end

endmodule

// File: rtl/order_map.sv
// Module: order_map
// Maps start bits and beat number to the low address bits in the selected
// order. The mode is expected to stay static while a burst is running.
module order_map
    import burst_pkg::*;
(
    input  logic  mode_linear,
    input  beat_t start_bits,
    input  beat_t beat,
    output beat_t low_bits
);

    beat_t seq_x;
    beat_t seq_l;

    // Per-bit interleave: each low bit flips where the beat number has a one.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
        assign seq_x[b] = start_bits[b] ^ beat[b];
    end

    // Order select: linear sum or interleaved XOR.
    always_comb begin
        seq_l    = order_linear(start_bits, beat);
        low_bits = mode_linear ? seq_l : seq_x;
    end

endmodule

// File: rtl/burst_addr_gen.sv
// Module: burst_addr_gen (top)
// Four-beat burst address counter. A strobe loads the full address, advance
// steps the two low bits in interleaved or linear order, and the upper bits
// stay fixed until the next strobe. Assumes ADDR_W > 2 and a static mode.
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_linear,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              advance_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [1:0]        beat_idx,
    output logic              burst_src
);

    localparam int UP_W = ADDR_W - BEAT_W;

    logic            do_load;
    logic            do_step;
    burst_src_e      load_src;
    burst_src_e      src_q;
    beat_t           start_q;
    beat_t           beat_q;
    beat_t           low_bits;
    logic [UP_W-1:0] upper_q;

    strobe_arbiter u_arb (
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .advance_n     (advance_n),
        .do_load       (do_load),
        .do_step       (do_step),
        .load_src      (load_src)
    );

    beat_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_load  (do_load),
        .do_step  (do_step),
        .start_in (addr_in[BEAT_W-1:0]),
        .start_q  (start_q),
        .beat_q   (beat_q)
    );

    upper_hold #(.UP_W(UP_W)) u_up (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_load  (do_load),
        .upper_in (addr_in[ADDR_W-1:BEAT_W]),
        .src_in   (load_src),
        .upper_q  (upper_q),
        .src_q    (src_q)
    );

    order_map u_map (
        .mode_linear (mode_linear),
        .start_bits  (start_q),
        .beat        (beat_q),
        .low_bits    (low_bits)
    );

    // Output assembly: held upper bits joined with the ordered low bits.
    always_comb begin
        addr_out  = {upper_q, low_bits};
        beat_idx  = beat_q;
        burst_src = src_q;
    end

endmodule

// File: rtl/burst_addr_gen_chk.sv
// Module: burst_addr_gen_chk
// Checks the port-level behaviour of burst_addr_gen. It keeps its own copy of
// the loaded start bits so that the ordering can be checked on its own terms.
module burst_addr_gen_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_linear,
    input logic              proc_strobe_n,
    input logic              ctrl_strobe_n,
    input logic              advance_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic [1:0]        beat_idx,
    input logic              burst_src
);

    logic [1:0] ref_start;
    logic       strobe;
    assign strobe = !proc_strobe_n || !ctrl_strobe_n;

    // Shadow of the burst start bits, taken from the inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_start <= '0;
        else if (strobe)
            ref_start <= addr_in[1:0];
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (addr_out == $past(addr_in)) && (beat_idx == 2'd0));

    assert_proc_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !proc_strobe_n |=> burst_src == 1'b0);

    assert_ctrl_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strobe_n && !ctrl_strobe_n) |=> burst_src == 1'b1);

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !advance_n) |=> beat_idx == 2'($past(beat_idx) + 2'd1));

    assert_interleave_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_linear |-> addr_out[1:0] == (ref_start ^ beat_idx));

    assert_linear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_linear |-> addr_out[1:0] == 2'(ref_start + beat_idx));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && advance_n) |=> $stable(beat_idx) && $stable(burst_src));

    assert_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(addr_out[ADDR_W-1:2]));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_linear   (mode_linear),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .advance_n     (advance_n),
    .addr_in       (addr_in),
    .addr_out      (addr_out),
    .beat_idx      (beat_idx),
    .burst_src     (burst_src)
);

// File: tb/sim_burst_addr_gen.sv
// Bench: sweeps mode, start bits, upper patterns and strobe kinds, and
// compares every cycle against an arithmetic model of the requirements.
module sim_burst_addr_gen;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 17;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_linear = 1'b0;
    logic              proc_strobe_n = 1'b1;
    logic              ctrl_strobe_n = 1'b1;
    logic              advance_n = 1'b1;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [ADDR_W-1:0] addr_out;
    logic [1:0]        beat_idx;
    logic              burst_src;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state
    logic [1:0]        m_start = '0;
    logic [1:0]        m_beat  = '0;
    logic [ADDR_W-3:0] m_upper = '0;
    logic              m_src   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_linear   (mode_linear),
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .advance_n     (advance_n),
        .addr_in       (addr_in),
        .addr_out      (addr_out),
        .beat_idx      (beat_idx),
        .burst_src     (burst_src)
    );

    function automatic logic [ADDR_W-1:0] exp_addr();
        logic [1:0] lo;
        lo = mode_linear ? 2'(m_start + m_beat) : (m_start ^ m_beat);
        return {m_upper, lo};
    endfunction

    task automatic check_all(input string req);
        logic [ADDR_W-1:0] ea;
        ea = exp_addr();
        checks++;
        if (addr_out !== ea || beat_idx !== m_beat || burst_src !== m_src) begin
            fails++;
            $display("FAIL %s: addr=%h beat=%0d src=%0d expected addr=%h beat=%0d src=%0d",
                     req, addr_out, beat_idx, burst_src, ea, m_beat, m_src);
        end
    endtask

    // One edge with the given inputs; updates the model, then checks.
    task automatic step(input logic p_n, input logic c_n, input logic adv_n,
                        input logic [ADDR_W-1:0] a, input string req);
        @(negedge clk);
        proc_strobe_n = p_n;
        ctrl_strobe_n = c_n;
        advance_n     = adv_n;
        addr_in       = a;
        @(posedge clk);
        #1;
        if (!p_n || !c_n) begin
            m_start = a[1:0];
            m_upper = a[ADDR_W-1:2];
            m_beat  = 2'd0;
            m_src   = p_n ? 1'b1 : 1'b0;
        end else if (!adv_n) begin
            m_beat = m_beat + 2'd1;
        end
        check_all(req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-3:0] uppers [3];
        uppers[0] = '0;
        uppers[1] = '1;
        uppers[2] = 15'h2A5C;

        // R1: reset state, held and first edge after release
        repeat (3) @(posedge clk);
        #1;
        check_all("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_all("R1");

        for (int md = 0; md < 2; md++) begin
            mode_linear = md[0];
            for (int s = 0; s < 4; s++) begin
                for (int u = 0; u < 3; u++) begin
                    for (int k = 0; k < 3; k++) begin
                        logic p_n, c_n;
                        logic [ADDR_W-1:0] a, a2;
                        p_n = (k == 1);            // k=0 proc, k=1 ctrl, k=2 both
                        c_n = (k == 0);
                        a   = {uppers[u], 2'(s)};
                        // R2/R3: load
                        step(p_n, c_n, 1'b1, a, "R2_R3");
                        // R4/R5/R6: walk with holds between (R7, R8)
                        for (int b = 0; b < 4; b++) begin
                            step(1'b1, 1'b1, 1'b0, ~a,
                                 md[0] ? "R4_R6" : "R4_R5");
                            step(1'b1, 1'b1, 1'b1, a ^ 17'h1FFFF, "R7_R8");
                        end
                        // R10: after four advances, back at start
                        checks++;
                        if (addr_out !== a) begin
                            fails++;
                            $display("FAIL R10: addr=%h expected=%h", addr_out, a);
                        end
                        // Partial walk, then restart with advance low (R9)
                        step(1'b1, 1'b1, 1'b0, a, "R4");
                        a2 = {~uppers[u], 2'(3 - s)};
                        step(c_n, p_n, 1'b0, a2, "R9");
                        step(1'b1, 1'b1, 1'b0, a, "R8");
                    end
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule